// File: doc/BRIEF.md
# Sample-Skipping Input Shift Aligner

This block sits at the front of a serial timing-recovery chain that runs at two samples per symbol. Each clock it can take one pair of complex samples, and it keeps a window of the most recent samples. The interpolation filter that follows reads this window. The receiver clock runs slightly faster than the far-end clock, so over time more samples arrive than symbols exist. The timing loop corrects for this by raising a skip request. The aligner then throws away exactly one sample, and later windows stay centred on symbol boundaries.

Each incoming pair is first captured in an input register. A small control stage consumes that pair on the next enabled cycle. The control stage merges the pair with at most one held-over sample and drops the oldest pending sample when a skip is requested. If at least two samples remain, it shifts two of them into the window. A registered strobe goes high exactly on the cycles that follow a window advance, so downstream logic knows which outputs are real symbols.

A synchronous reset clears everything. An enable input freezes the whole block without losing data.

Top module: `sas_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, the window, the input register, the held-over sample and `wr_valid` are all cleared after that edge. Every window slot reads zero and `wr_valid` reads 0.
- R2: When the block consumes a pair with no held-over sample and no skip, the window shifts by two. Slot 0 (bits [SW-1:0]) takes the newer sample `smp1`, slot 1 takes the older sample `smp0`, slot k takes the old slot k-2, and `wr_valid` is 1 after that edge.
- R3: A pair presented with `go` high is stored in the input register at that edge and consumed at the next edge where `go` is high. The first enabled cycle after reset therefore leaves the window unchanged and `wr_valid` at 0.
- R4: When a skip is requested while a pair is consumed and no sample is held over, the older sample of the pair is discarded and the newer one is held over. The window does not move and `wr_valid` is 0.
- R5: When a skip is requested while a pair is consumed and a sample is held over, the held-over sample is discarded. The pair shifts in as in R2, nothing remains held over, and `wr_valid` is 1.
- R6: When a pair is consumed with a held-over sample and no skip, the window shifts in the held-over sample (slot 1) and the pair's older sample (slot 0). The pair's newer sample becomes the held-over sample, and `wr_valid` is 1.
- R7: During a cycle with `go` low, the window, the input register and the held-over sample keep their contents, and `wr_valid` is 0 after that edge. Data held across the pause resumes in order.
- R8: `skip_req` has no effect unless `go` is high and the input register holds a pair. The window, `wr_valid` and later outputs are the same as without the request.
- R9: The I and Q lanes of every sample travel together. `win_q` holds the Q components in exactly the slots where `win_i` holds the matching I components.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Enable; low freezes the block |
| skip_req | input | 1 | Drop one sample on this consuming cycle |
| smp0_i | input | SW | I component of the older sample of the pair |
| smp0_q | input | SW | Q component of the older sample of the pair |
| smp1_i | input | SW | I component of the newer sample of the pair |
| smp1_q | input | SW | Q component of the newer sample of the pair |
| win_i | output | DEPTH*SW | I window, slot k at bits [k*SW +: SW], slot 0 newest |
| win_q | output | DEPTH*SW | Q window, same slot layout |
| wr_valid | output | 1 | High for one cycle after each window advance |

## Verification
A pair driven with `go` high reaches the window one further enabled edge later. This follows from the input register, so with `go` held high the pair's effect on `win_i`, `win_q` and `wr_valid` appears after the second rising edge. A skip request acts at the edge where it is sampled and changes the outputs right after that same edge. The bench drives inputs on the falling edge and advances its queue-based model at the next rising edge from the values it just drove. It compares all three outputs at the following falling edge, so every check lands one cycle after the edge that caused the change. Directed runs walk through each consume case in turn before a long seeded random run with pauses and skips.

// File: rtl/sas_pkg.sv
package sas_pkg;

  // How a consumed pair is merged with the held-over sample
  typedef enum logic [1:0] {
    TAKE_PAIR = 2'd0,  // no hold, no skip: shift p0,p1
    TAKE_HELD = 2'd1,  // hold, no skip: shift hold,p0; keep p1
    DROP_WAIT = 2'd2,  // no hold, skip: drop p0, keep p1, no shift
    DROP_HELD = 2'd3   // hold, skip: drop hold, shift p0,p1
  } take_e;

  function automatic take_e take_mode(input logic held, input logic skip);
    take_e m;
    case ({skip, held})
      2'b00:   m = TAKE_PAIR;
      2'b01:   m = TAKE_HELD;
      2'b10:   m = DROP_WAIT;
      default: m = DROP_HELD;
    endcase
    return m;
  endfunction

  // A window advance happens in every mode but the waiting drop
  function automatic logic mode_shifts(input take_e m);
    return (m != DROP_WAIT);
  endfunction

  // Modes that leave one sample pending afterwards
  function automatic logic mode_holds(input take_e m);
    return (m == TAKE_HELD) || (m == DROP_WAIT);
  endfunction

  // The held sample goes first only when it is neither dropped nor absent
  function automatic logic held_leads(input take_e m);
    return (m == TAKE_HELD);
  endfunction

endpackage

// File: rtl/sas_in_reg.sv
module sas_in_reg #(
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] d0_i,
  input  logic [SW-1:0] d0_q,
  input  logic [SW-1:0] d1_i,
  input  logic [SW-1:0] d1_q,
  output logic [SW-1:0] q0_i,
  output logic [SW-1:0] q0_q,
  output logic [SW-1:0] q1_i,
  output logic [SW-1:0] q1_q,
  output logic          full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q0_i <= '0;
      q0_q <= '0;
      q1_i <= '0;
      q1_q <= '0;
      full <= 1'b0;
    end else if (load) begin
      q0_i <= d0_i;
      q0_q <= d0_q;
      q1_i <= d1_i;
      q1_q <= d1_q;
      full <= 1'b1;
    end
  end

endmodule

// File: rtl/sas_skip_ctrl.sv
module sas_skip_ctrl
  import sas_pkg::*;
#(
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          consume,
  input  logic          skip,
  input  logic [SW-1:0] p0_i,
  input  logic [SW-1:0] p0_q,
  input  logic [SW-1:0] p1_i,
  input  logic [SW-1:0] p1_q,
  output logic [SW-1:0] old_i,
  output logic [SW-1:0] old_q,
  output logic [SW-1:0] new_i,
  output logic [SW-1:0] new_q,
  output logic          shift_en,
  output logic          held_vld
);

  logic [SW-1:0] held_i, held_q;
  take_e         mode;

  always_comb begin
    mode     = take_mode(held_vld, skip);
    shift_en = consume && mode_shifts(mode);
    if (held_leads(mode)) begin
      old_i = held_i;
      old_q = held_q;
      new_i = p0_i;
      new_q = p0_q;
    end else begin
      old_i = p0_i;
      old_q = p0_q;
      new_i = p1_i;
      new_q = p1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_vld <= 1'b0;
      held_i   <= '0;
      held_q   <= '0;
    end else if (consume) begin
      held_vld <= mode_holds(mode);
      held_i   <= p1_i;
      held_q   <= p1_q;
    end
  end

endmodule

// File: rtl/sas_window.sv
module sas_window #(
  parameter int SW    = 7,
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic [SW-1:0]       old_i,
  input  logic [SW-1:0]       old_q,
  input  logic [SW-1:0]       new_i,
  input  logic [SW-1:0]       new_q,
  output logic [DEPTH*SW-1:0] win_i,
  output logic [DEPTH*SW-1:0] win_q
);

  logic [SW-1:0] tap_i [DEPTH];
  logic [SW-1:0] tap_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    logic [SW-1:0] src_i, src_q;
    if (k == 0) begin : g_newest
      assign src_i = new_i;
      assign src_q = new_q;
    end else if (k == 1) begin : g_second
      assign src_i = old_i;
      assign src_q = old_q;
    end else begin : g_older
      assign src_i = tap_i[k-2];
      assign src_q = tap_q[k-2];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tap_i[k] <= '0;
        tap_q[k] <= '0;
      end else if (shift_en) begin
        tap_i[k] <= src_i;
        tap_q[k] <= src_q;
      end
    end

    assign win_i[k*SW +: SW] = tap_i[k];
    assign win_q[k*SW +: SW] = tap_q[k];
  end

endmodule

// File: rtl/sas_aligner.sv
module sas_aligner #(
  parameter int SW    = 7,
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                skip_req,
  input  logic [SW-1:0]       smp0_i,
  input  logic [SW-1:0]       smp0_q,
  input  logic [SW-1:0]       smp1_i,
  input  logic [SW-1:0]       smp1_q,
  output logic [DEPTH*SW-1:0] win_i,
  output logic [DEPTH*SW-1:0] win_q,
  output logic                wr_valid
);

  logic [SW-1:0] r0_i, r0_q, r1_i, r1_q;
  logic [SW-1:0] o_i, o_q, n_i, n_q;
  logic          in_full;
  logic          consume;
  logic          shift_en;
  logic          held_vld;

  assign consume = go && in_full;

  sas_in_reg #(.SW(SW)) u_in (
    .clk  (clk),
    .rst  (rst),
    .load (go),
    .d0_i (smp0_i),
    .d0_q (smp0_q),
    .d1_i (smp1_i),
    .d1_q (smp1_q),
    .q0_i (r0_i),
    .q0_q (r0_q),
    .q1_i (r1_i),
    .q1_q (r1_q),
    .full (in_full)
  );

  sas_skip_ctrl #(.SW(SW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .consume  (consume),
    .skip     (skip_req),
    .p0_i     (r0_i),
    .p0_q     (r0_q),
    .p1_i     (r1_i),
    .p1_q     (r1_q),
    .old_i    (o_i),
    .old_q    (o_q),
    .new_i    (n_i),
    .new_q    (n_q),
    .shift_en (shift_en),
    .held_vld (held_vld)
  );

  sas_window #(.SW(SW), .DEPTH(DEPTH)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .old_i    (o_i),
    .old_q    (o_q),
    .new_i    (n_i),
    .new_q    (n_q),
    .win_i    (win_i),
    .win_q    (win_q)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_valid <= 1'b0;
    else     wr_valid <= shift_en;
  end

endmodule

// File: rtl/sas_aligner_chk.sv
module sas_aligner_chk #(
  parameter int SW    = 7,
  parameter int DEPTH = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                go,
  input logic                skip_req,
  input logic                in_full,
  input logic                held_vld,
  input logic                wr_valid,
  input logic [DEPTH*SW-1:0] win_i,
  input logic [DEPTH*SW-1:0] win_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!wr_valid && !held_vld && !in_full));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> !wr_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> ($stable(win_i) && $stable(win_q) && $stable(held_vld)));

  // R4
  drop_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (go && in_full && skip_req && !held_vld) |=> (!wr_valid && held_vld && $stable(win_i)));

  // R5
  drop_held_chk: assert property (@(posedge clk) disable iff (rst)
    (go && in_full && skip_req && held_vld) |=> (wr_valid && !held_vld));

  // R2
  pair_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (go && in_full && !skip_req) |=> (wr_valid && ($past(held_vld) == held_vld)));

  // R8
  skip_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !(go && in_full) |=> (!wr_valid && $stable(held_vld)));

endmodule

bind sas_aligner sas_aligner_chk #(.SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .skip_req (skip_req),
  .in_full  (in_full),
  .held_vld (held_vld),
  .wr_valid (wr_valid),
  .win_i    (win_i),
  .win_q    (win_q)
);

// File: tb/test_sas_aligner.sv
module test_sas_aligner;

  localparam int SW    = 7;
  localparam int DEPTH = 16;
  localparam int VW    = DEPTH * SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          go = 1'b0;
  logic          skip_req = 1'b0;
  logic [SW-1:0] smp0_i = '0, smp0_q = '0, smp1_i = '0, smp1_q = '0;
  logic [VW-1:0] win_i, win_q;
  logic          wr_valid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sas_aligner #(.SW(SW), .DEPTH(DEPTH)) i_sas_aligner (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .skip_req (skip_req),
    .smp0_i   (smp0_i),
    .smp0_q   (smp0_q),
    .smp1_i   (smp1_i),
    .smp1_q   (smp1_q),
    .win_i    (win_i),
    .win_q    (win_q),
    .wr_valid (wr_valid)
  );

  // Model: pending-sample queue in arrival order, window newest-first
  logic [2*SW-1:0] mq[$];
  logic [SW-1:0]   mwi [DEPTH];
  logic [SW-1:0]   mwq [DEPTH];
  logic [2*SW-1:0] m_in0, m_in1;
  logic            m_full;
  logic            m_wr;

  function automatic logic [VW-1:0] pack_lane(input logic q_lane);
    logic [VW-1:0] v = '0;
    for (int k = 0; k < DEPTH; k++)
      v[k*SW +: SW] = q_lane ? mwq[k] : mwi[k];
    return v;
  endfunction

  task automatic model_clear();
    mq.delete();
    for (int k = 0; k < DEPTH; k++) begin
      mwi[k] = '0;
      mwq[k] = '0;
    end
    m_in0 = '0; m_in1 = '0; m_full = 1'b0; m_wr = 1'b0;
  endtask

  task automatic model_step(input logic g, input logic sk,
                            input logic [2*SW-1:0] a, input logic [2*SW-1:0] b);
    logic [2*SW-1:0] s_old, s_new;
    m_wr = 1'b0;
    if (g) begin
      if (m_full) begin
        mq.push_back(m_in0);
        mq.push_back(m_in1);
        if (sk) void'(mq.pop_front());
        if (mq.size() >= 2) begin
          s_old = mq.pop_front();
          s_new = mq.pop_front();
          for (int k = DEPTH - 1; k >= 2; k--) begin
            mwi[k] = mwi[k-2];
            mwq[k] = mwq[k-2];
          end
          mwi[1] = s_old[2*SW-1:SW]; mwq[1] = s_old[SW-1:0];
          mwi[0] = s_new[2*SW-1:SW]; mwq[0] = s_new[SW-1:0];
          m_wr = 1'b1;
        end
      end
      m_in0 = a; m_in1 = b; m_full = 1'b1;
    end
  endtask

  task automatic check_bits(input string req, input string what,
                            input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check_bits(req, "wr_valid", {{(VW-1){1'b0}}, wr_valid}, {{(VW-1){1'b0}}, m_wr});
    check_bits(req, "win_i", win_i, pack_lane(1'b0));
    check_bits("R9", "win_q", win_q, pack_lane(1'b1));
  endtask

  // Drive at falling edge, model the next rising edge, compare at the next falling edge
  task automatic step(input logic g, input logic sk, input string tag);
    logic [2*SW-1:0] a, b;
    string req;
    a = 14'($urandom);
    b = 14'($urandom);
    if (tag != "") req = tag;
    else if (!g)                        req = sk ? "R8" : "R7";
    else if (!m_full)                   req = sk ? "R8" : "R3";
    else if (sk && mq.size() == 1)      req = "R5";
    else if (sk)                        req = "R4";
    else if (mq.size() == 1)            req = "R6";
    else                                req = "R2";
    go = g; skip_req = sk;
    smp0_i = a[2*SW-1:SW]; smp0_q = a[SW-1:0];
    smp1_i = b[2*SW-1:SW]; smp1_q = b[SW-1:0];
    model_step(g, sk, a, b);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1'b1; go = 1'b0; skip_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_clear();
    compare("R1");
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    @(negedge clk);
    do_reset();

    // Directed corner cases
    step(1'b1, 1'b1, "R8");  // skip with empty input register
    step(1'b1, 1'b0, "R3");  // first real consume
    step(1'b1, 1'b1, "");    // R4: drop older, hold newer
    step(1'b1, 1'b0, "");    // R6: held sample leads
    step(1'b0, 1'b1, "");    // R8: skip while paused
    step(1'b0, 1'b0, "");    // R7: pause
    step(1'b1, 1'b1, "");    // R5: drop the held sample
    step(1'b1, 1'b0, "");    // R2
    step(1'b1, 1'b1, "");    // R4 again
    step(1'b1, 1'b1, "");    // R5 back to back

    // Reset in mid-stream with a pending sample
    step(1'b1, 1'b1, "");
    do_reset();
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "");

    // Seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 100) < 85, ($urandom % 100) < 20, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule